// File: doc/BRIEF.md
# Hardware Semaphore Bank

A bank of single-bit mutual-exclusion flags that several processors share over a simple APB-style register bus. Every flag has its own 32-bit word. A read of that word is an atomic test-and-set. It returns 0 if the flag was free and claims the flag in the same access. It returns 1 if another requester already holds the flag. A write of zero hands the flag back.

The bank size is a parameter and must be 32, 64, 128 or 256. A read-only status word tells software how large the bank is, so a driver can size its tables at start-up. Every access finishes in a single access phase with no wait states. Because the bus carries one access at a time, two requesters that race for the same flag are ordered by the bus. Only the first access to be granted can see the flag free.

Top module: `hw_sem_bank`

## Requirements
- R1: After reset, whether from power-up or asserted mid-run, every flag is free, so the first read of any flag returns 0.
- R2: A read access to a free flag returns 0 in that access phase and leaves the flag taken from the next cycle on.
- R3: A read access to a taken flag returns 1 and leaves the flag taken.
- R4: A write access of the value 0 to a flag's word makes that flag free.
- R5: A write access of any nonzero value to a flag's word leaves that flag unchanged.
- R6: Flag i sits at byte address 0x800 + 4*i, for i from 0 to NUM_LOCKS-1. An access to one flag changes no other flag.
- R7: A read of byte address 0x14 returns NUM_LOCKS/32 in bits 27:24 (a one-hot code: 1, 2, 4 or 8) and 0 in all other bits. It has no side effect, and writes to it are ignored.
- R8: Reads of unmapped addresses return 0 and writes to them change no flag. Unmapped addresses include the addresses past the last flag and addresses that are not word aligned.
- R9: pready_o is high during every access phase, and prdata_o is valid in that same phase (zero wait states).
- R10: Of two consecutive read accesses to the same free flag, only the first returns 0.
- R11: Bus cycles that are not access phases change no flag. This covers cycles where psel_i is low and setup phases where penable_i is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psel_i | input | 1 | Select; marks the setup and access phases |
| penable_i | input | 1 | High in the access phase |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | ADDR_W | Byte address |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, valid in the access phase |
| pready_o | output | 1 | Transfer complete |

## Verification
The read result of an access is combinational: it is due in the access phase itself. The bench therefore samples prdata_o and pready_o a short delay after raising penable_i, and well before the closing clock edge. Changes in flag state, whether claims or releases, only take effect at the edge that ends the access phase. They are observed through the next read access, which is never earlier than one full setup-plus-access transfer later. Ignored accesses are proven the same way: a later read of the flag that could have been disturbed must return the expected value.

// File: rtl/hw_sem_pkg.sv
package hw_sem_pkg;
  localparam int unsigned LOCK_BASE = 32'h800;
  localparam int unsigned STAT_ADDR = 32'h14;
  localparam int unsigned CNT_LSB   = 24;

  function automatic logic [31:0] stat_word(input int unsigned n);
    logic [31:0] code;
    code = 32'(n / 32);
    return code << CNT_LSB;
  endfunction
endpackage

// File: rtl/hw_sem_decode.sv
module hw_sem_decode #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_LOCKS = 64,
  parameter int unsigned IDX_W     = $clog2(NUM_LOCKS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              lock_hit_o,
  output logic              stat_hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  import hw_sem_pkg::*;

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] word;

  always_comb begin
    off        = addr_i - ADDR_W'(LOCK_BASE);
    word       = {2'b00, off[ADDR_W-1:2]};
    lock_hit_o = (addr_i >= ADDR_W'(LOCK_BASE)) && (off[1:0] == 2'b00) &&
                 (word < ADDR_W'(NUM_LOCKS));
    idx_o      = off[IDX_W+1:2];
    stat_hit_o = (addr_i == ADDR_W'(STAT_ADDR));
  end
endmodule

// File: rtl/hw_sem_array.sv
module hw_sem_array #(
  parameter int unsigned NUM_LOCKS = 64,
  parameter int unsigned IDX_W     = $clog2(NUM_LOCKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_i,
  input  logic                 clr_i,
  input  logic [IDX_W-1:0]     idx_i,
  output logic [NUM_LOCKS-1:0] lock_o
);
  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_flag
    logic sel;
    assign sel = (idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            lock_o[g] <= 1'b0;
      else if (sel && set_i)  lock_o[g] <= 1'b1;
      else if (sel && clr_i)  lock_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/hw_sem_bank.sv
module hw_sem_bank #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_LOCKS = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [31:0]       pwdata_i,
  output logic [31:0]       prdata_o,
  output logic              pready_o
);
  import hw_sem_pkg::*;

  localparam int unsigned IDX_W = $clog2(NUM_LOCKS);

  if (!(NUM_LOCKS == 32 || NUM_LOCKS == 64 || NUM_LOCKS == 128 || NUM_LOCKS == 256))
    $error("NUM_LOCKS must be 32, 64, 128 or 256");
  if (ADDR_W < 12) $error("ADDR_W too small for lock window");

  logic                 lock_hit, stat_hit;
  logic [IDX_W-1:0]     idx;
  logic                 rd_acc, wr_acc;
  logic [NUM_LOCKS-1:0] lock_q;

  hw_sem_decode #(.ADDR_W(ADDR_W), .NUM_LOCKS(NUM_LOCKS), .IDX_W(IDX_W)) u_dec (
    .addr_i     (paddr_i),
    .lock_hit_o (lock_hit),
    .stat_hit_o (stat_hit),
    .idx_o      (idx)
  );

  assign rd_acc = psel_i && penable_i && !pwrite_i;
  assign wr_acc = psel_i && penable_i &&  pwrite_i;

  // Test-and-set: read returns old value, claims at the closing edge
  hw_sem_array #(.NUM_LOCKS(NUM_LOCKS), .IDX_W(IDX_W)) u_arr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (rd_acc && lock_hit),
    .clr_i  (wr_acc && lock_hit && (pwdata_i == 32'd0)),
    .idx_i  (idx),
    .lock_o (lock_q)
  );

  always_comb begin
    prdata_o = 32'd0;
    if (psel_i && !pwrite_i) begin
      if (lock_hit)      prdata_o = {31'd0, lock_q[idx]};
      else if (stat_hit) prdata_o = stat_word(NUM_LOCKS);
    end
  end

  assign pready_o = psel_i;
endmodule

// File: rtl/hw_sem_chk.sv
module hw_sem_chk #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_LOCKS = 64
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 psel_i,
  input logic                 penable_i,
  input logic                 pwrite_i,
  input logic [ADDR_W-1:0]    paddr_i,
  input logic [31:0]          pwdata_i,
  input logic [31:0]          prdata_o,
  input logic                 pready_o,
  input logic [NUM_LOCKS-1:0] lock_q
);
  localparam int unsigned IDX_W = $clog2(NUM_LOCKS);

  logic              acc, rd, wr, hit;
  logic [ADDR_W-1:0] rel;
  logic [IDX_W-1:0]  li;

  assign acc = psel_i && penable_i;
  assign rd  = acc && !pwrite_i;
  assign wr  = acc && pwrite_i;
  assign rel = paddr_i - ADDR_W'(12'h800);
  assign hit = (paddr_i >= ADDR_W'(12'h800)) && (rel < ADDR_W'(4 * NUM_LOCKS)) &&
               (paddr_i[1:0] == 2'b00);
  assign li  = rel[IDX_W+1:2];

  a_r2_free_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && hit && !lock_q[li]) |-> (prdata_o == 32'd0));
  a_r2_claim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && hit) |=> lock_q[$past(li)]);
  a_r3_taken_reads_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && hit && lock_q[li]) |-> (prdata_o == 32'd1));
  a_r4_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && hit && pwdata_i == 32'd0) |=> !lock_q[$past(li)]);
  a_r5_nonzero_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && pwdata_i != 32'd0) |=> $stable(lock_q));
  a_r7_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && paddr_i == ADDR_W'(12'h014)) |-> (prdata_o == (32'(NUM_LOCKS / 32) << 24)));
  a_r8_unmapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !hit) |=> $stable(lock_q));
  a_r9_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |-> pready_o);
  a_r11_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> $stable(lock_q));
endmodule

bind hw_sem_bank hw_sem_chk #(.ADDR_W(ADDR_W), .NUM_LOCKS(NUM_LOCKS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .psel_i    (psel_i),
  .penable_i (penable_i),
  .pwrite_i  (pwrite_i),
  .paddr_i   (paddr_i),
  .pwdata_i  (pwdata_i),
  .prdata_o  (prdata_o),
  .pready_o  (pready_o),
  .lock_q    (lock_q)
);

// File: tb/hw_sem_bank_tb.sv
module hw_sem_bank_tb;
  localparam int unsigned ADDR_W = 12;
  localparam logic [31:0] STAT   = 32'h0200_0000;

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VT [NV] = '{
    '{1'b0, 12'h800, 32'd0, 32'd0, 8'd2},   // R2 free read
    '{1'b0, 12'h800, 32'd0, 32'd1, 8'd2},   // R2 now taken
    '{1'b0, 12'h800, 32'd0, 32'd1, 8'd3},   // R3 stays taken
    '{1'b0, 12'h804, 32'd0, 32'd0, 8'd6},   // R6 neighbour untouched
    '{1'b1, 12'h800, 32'd5, 32'd0, 8'd5},   // R5 nonzero write
    '{1'b0, 12'h800, 32'd0, 32'd1, 8'd5},
    '{1'b1, 12'h800, 32'd0, 32'd0, 8'd4},   // R4 release
    '{1'b0, 12'h800, 32'd0, 32'd0, 8'd4},
    '{1'b0, 12'h014, 32'd0, STAT,  8'd7},   // R7 status
    '{1'b0, 12'h014, 32'd0, STAT,  8'd7},
    '{1'b0, 12'h8FC, 32'd0, 32'd0, 8'd6},   // R6 last flag
    '{1'b0, 12'h8FC, 32'd0, 32'd1, 8'd6},
    '{1'b0, 12'h900, 32'd0, 32'd0, 8'd8},   // R8 past end
    '{1'b0, 12'h900, 32'd0, 32'd0, 8'd8},
    '{1'b1, 12'h8FE, 32'd0, 32'd0, 8'd8},   // R8 misaligned write
    '{1'b0, 12'h8FC, 32'd0, 32'd1, 8'd8},
    '{1'b0, 12'h802, 32'd0, 32'd0, 8'd8},
    '{1'b0, 12'h000, 32'd0, 32'd0, 8'd8},
    '{1'b1, 12'h014, 32'hFFFF_FFFF, 32'd0, 8'd7},
    '{1'b0, 12'h014, 32'd0, STAT,  8'd7},
    '{1'b0, 12'h808, 32'd0, 32'd0, 8'd6}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              psel_i = 1'b0, penable_i = 1'b0, pwrite_i = 1'b0;
  logic [ADDR_W-1:0] paddr_i = '0;
  logic [31:0]       pwdata_i = '0;
  logic [31:0]       prdata_o;
  logic              pready_o;
  int checks = 0, failures = 0;

  always #5 clk_i = ~clk_i;

  hw_sem_bank #(.ADDR_W(ADDR_W), .NUM_LOCKS(64)) u_dut (.*);

  function automatic string rname(input int n);
    case (n)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Setup phase, access phase; samples 2 ns into the access phase
  task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output logic rdy);
    @(negedge clk_i);
    psel_i = 1'b1; penable_i = 1'b0; pwrite_i = wr; paddr_i = a; pwdata_i = d;
    @(negedge clk_i);
    penable_i = 1'b1;
    #2;
    rd = prdata_o; rdy = pready_o;
    @(negedge clk_i);
    psel_i = 1'b0; penable_i = 1'b0; pwrite_i = 1'b0;
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; failures++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        rdy;
    #12;
    check("R1 idle rdata in reset", prdata_o, 32'd0);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      xfer(VT[i].wr, VT[i].addr, VT[i].wd, rd, rdy);
      check("R9 ready", {31'd0, rdy}, 32'd1);
      if (!VT[i].wr) check(rname(int'(VT[i].req)), rd, VT[i].exp);
    end
    // R11: setup-only phase and penable without psel must not claim
    @(negedge clk_i);
    psel_i = 1'b1; pwrite_i = 1'b0; paddr_i = 12'h810;
    @(negedge clk_i);
    psel_i = 1'b0; penable_i = 1'b1;
    @(negedge clk_i);
    penable_i = 1'b0;
    xfer(1'b0, 12'h810, 32'd0, rd, rdy);
    check("R11", rd, 32'd0);
    // R10: back-to-back reads of a free flag
    xfer(1'b0, 12'h8A0, 32'd0, rd, rdy);
    check("R10 first", rd, 32'd0);
    xfer(1'b0, 12'h8A0, 32'd0, rd, rdy);
    check("R10 second", rd, 32'd1);
    // R1: mid-run reset frees taken flags
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    xfer(1'b0, 12'h8A0, 32'd0, rd, rdy);
    check("R1 after reset", rd, 32'd0);
    xfer(1'b0, 12'h8FC, 32'd0, rd, rdy);
    check("R1 last flag after reset", rd, 32'd0);
    report();
    $finish;
  end
endmodule